// File: doc/BRIEF.md
# Serial Register Front End for a Sixteen-Channel Blink Controller

This block is the two-wire serial slave that sits in front of a sixteen-channel LED blink controller. It watches the synchronised clock and data lines, spots start and stop conditions, and answers only to its own seven-bit device address. The upper four bits of that address are fixed and the lower three come from strap inputs. After it is selected for a write, the first byte it receives sets a five-bit register pointer. Each later byte is stored in the configuration register that the pointer selects. When the device is selected for a read, it shifts out the selected register, most significant bit first, on an open-drain data enable.

The register space holds two read-only snapshots of the sixteen pin levels, two blink periods, two duty thresholds and four LED mode selector bytes. An auto-step flag in the pointer moves it to the next index after every data byte. The pointer wraps from the last register back to index zero. The stored values drive the blink and output logic directly. Each accepted configuration write is also announced by a one-cycle update strobe carrying the index and the data.

Top module: `led_i2c_regif`

## Requirements
- R1: The block acknowledges an address byte only when bits 7..4 equal binary 1100 and bits 3..1 equal `dev_sel_i`. Bit 0 selects the direction: 1 is a read, 0 is a write. On a mismatch the block never drives SDA until the next START or STOP.
- R2: In a write, the byte after the address is the pointer byte. Bits 3..0 are the index and bit 4 is the auto-step flag. Bits 7..5 are ignored. The slave acknowledges every byte of a write addressed to it.
- R3: Data bytes are stored at the pointed index. Index 2 is period A, 3 is duty A, 4 is period B, 5 is duty B, and 6..9 are LED selector bytes 0..3, where selector byte k sits at `ledsel_o[8k+7:8k]`. Each stored byte gives a one-cycle `upd_stb_o` with its index and data. Only indices 2..9 produce the strobe.
- R4: With the auto-step flag at 1, the index advances after every data byte that is written or read. Index 9 goes to 0, and every other index goes to index+1 modulo 16.
- R5: With the auto-step flag at 0, the index stays fixed across any number of data bytes.
- R6: A read returns the byte at the index, MSB first. Index 0 is `pin_lvl_i[7:0]` and index 1 is `pin_lvl_i[15:8]`. The pins are sampled at the SCL falling edge that ends the acknowledge clock before the byte.
- R7: Writes to indices 0, 1 and 10..15 are acknowledged and change no register. Reads of indices 10..15 return 00h.
- R8: If the master does not acknowledge a read byte, the slave releases SDA and ignores further clocks until a START or STOP.
- R9: A repeated START begins a new address phase and keeps the pointer. The pointer also persists across STOP.
- R10: While `rst_n` is low: periods read FFh, duties read 80h, selectors read 55h, the pointer is 00h with the auto-step flag clear, and SDA is released.
- R11: The slave changes its SDA drive only while SCL is low. A STOP always releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, holds defaults while low |
| dev_sel_i | input | 3 | Strap bits compared with address bits 3..1 |
| scl_i | input | 1 | Synchronised serial clock level |
| sda_i | input | 1 | Synchronised serial data level (bus value) |
| sda_oe_o | output | 1 | High pulls SDA low (open drain) |
| pin_lvl_i | input | 16 | Live levels of the sixteen LED pins |
| period_a_o | output | 8 | Blink A period setting |
| duty_a_o | output | 8 | Blink A duty threshold |
| period_b_o | output | 8 | Blink B period setting |
| duty_b_o | output | 8 | Blink B duty threshold |
| ledsel_o | output | 32 | Two-bit mode per LED, selector bytes 0..3 |
| upd_stb_o | output | 1 | One-cycle pulse per stored configuration byte |
| upd_idx_o | output | 4 | Index of the stored byte |
| upd_dat_o | output | 8 | Value of the stored byte |

## Verification
Several properties are checked on every cycle. A STOP releases the data line, and the slave never starts driving while SCL is high. Update strobes land only on writable indices. Every strobe leaves the pointer either stepped, wrapped from 9 to 0, or unchanged, according to the flag. Reset ends with a clean pointer. Other behaviours can only be shown by bench scenarios: address rejection, the pin snapshot on reads, dropped writes to read-only and unused indices, master NACK handling, and pointer survival across repeated START. In those scenarios the bus traffic is compared with a register model kept by the bench.

// File: rtl/lri_pkg.sv
package lri_pkg;

   typedef enum logic [3:0] {
      LK_IDLE,
      LK_ADDR,
      LK_ADDR_ACK,
      LK_CMD,
      LK_CMD_ACK,
      LK_WDATA,
      LK_WDATA_ACK,
      LK_RDATA,
      LK_RD_ACK,
      LK_WAIT
   } lk_state_e;

   localparam logic [3:0] DEV_PREFIX = 4'b1100;
   localparam int         STEP_BIT   = 4;
   localparam int         BYTE_W     = 8;
   localparam int         N_TIMING   = 4;

   localparam logic [7:0] PERIOD_RST = 8'hFF;
   localparam logic [7:0] DUTY_RST   = 8'h80;
   localparam logic [7:0] SEL_RST    = 8'h55;

   // reset value of configuration slot (slot 0 is the first writable index)
   function automatic logic [7:0] cfg_reset(input int unsigned slot);
      if (slot == 0 || slot == 2) return PERIOD_RST;
      if (slot == 1 || slot == 3) return DUTY_RST;
      return SEL_RST;
   endfunction

endpackage

// File: rtl/lri_bus_edges.sv
module lri_bus_edges (
   input  logic clk,
   input  logic rst_n,
   input  logic scl,
   input  logic sda,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   assign scl_rise  = scl & ~scl_q;
   assign scl_fall  = ~scl & scl_q;
   assign start_det = scl & scl_q & sda_q & ~sda;
   assign stop_det  = scl & scl_q & ~sda_q & sda;

endmodule

// File: rtl/lri_link.sv
module lri_link
   import lri_pkg::*;
#(
   parameter int IDX_W    = 4,
   parameter int N_IN     = 2,
   parameter int LAST_IDX = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       dev_sel,
   input  logic             sda,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic [7:0]       rd_dat,
   output logic [IDX_W-1:0] ptr_idx,
   output logic             ptr_step,
   output logic             sda_oe,
   output logic             upd_stb,
   output logic [IDX_W-1:0] upd_idx,
   output logic [7:0]       upd_dat
);

   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

   lk_state_e        st;
   logic [CNT_W-1:0] cnt;
   logic [7:0]       shreg;
   logic             rd_dir;
   logic             m_ack;

   function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] i);
      return (i == IDX_W'(LAST_IDX)) ? '0 : i + 1'b1;
   endfunction

   function automatic logic writable(input logic [IDX_W-1:0] i);
      return (i >= IDX_W'(N_IN)) && (i <= IDX_W'(LAST_IDX));
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= LK_IDLE;
         cnt      <= '0;
         shreg    <= '0;
         rd_dir   <= 1'b0;
         m_ack    <= 1'b0;
         sda_oe   <= 1'b0;
         ptr_idx  <= '0;
         ptr_step <= 1'b0;
         upd_stb  <= 1'b0;
         upd_idx  <= '0;
         upd_dat  <= '0;
      end else begin
         upd_stb <= 1'b0;
         if (stop_det) begin
            st     <= LK_IDLE;
            sda_oe <= 1'b0;
         end else if (start_det) begin
            st     <= LK_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else begin
            unique case (st)
               LK_ADDR, LK_CMD, LK_WDATA: begin
                  if (scl_rise && cnt != CNT_FULL) begin
                     shreg <= {shreg[6:0], sda};
                     cnt   <= cnt + 1'b1;
                  end else if (scl_fall && cnt == CNT_FULL) begin
                     cnt <= '0;
                     if (st == LK_ADDR) begin
                        if (shreg[7:1] == {DEV_PREFIX, dev_sel}) begin
                           rd_dir <= shreg[0];
                           sda_oe <= 1'b1;
                           st     <= LK_ADDR_ACK;
                        end else begin
                           st <= LK_WAIT;
                        end
                     end else if (st == LK_CMD) begin
                        ptr_step <= shreg[STEP_BIT];
                        ptr_idx  <= shreg[IDX_W-1:0];
                        sda_oe   <= 1'b1;
                        st       <= LK_CMD_ACK;
                     end else begin
                        upd_stb <= writable(ptr_idx);
                        upd_idx <= ptr_idx;
                        upd_dat <= shreg;
                        if (ptr_step) ptr_idx <= step_idx(ptr_idx);
                        sda_oe  <= 1'b1;
                        st      <= LK_WDATA_ACK;
                     end
                  end
               end
               LK_ADDR_ACK: begin
                  if (scl_fall) begin
                     if (rd_dir) begin
                        shreg  <= rd_dat;
                        sda_oe <= ~rd_dat[7];
                        cnt    <= '0;
                        st     <= LK_RDATA;
                     end else begin
                        sda_oe <= 1'b0;
                        st     <= LK_CMD;
                     end
                  end
               end
               LK_CMD_ACK, LK_WDATA_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     st     <= LK_WDATA;
                  end
               end
               LK_RDATA: begin
                  if (scl_rise) begin
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall) begin
                     if (cnt == CNT_FULL) begin
                        sda_oe <= 1'b0;
                        if (ptr_step) ptr_idx <= step_idx(ptr_idx);
                        st     <= LK_RD_ACK;
                     end else begin
                        shreg  <= {shreg[6:0], 1'b0};
                        sda_oe <= ~shreg[6];
                     end
                  end
               end
               LK_RD_ACK: begin
                  if (scl_rise) begin
                     m_ack <= ~sda;
                  end else if (scl_fall) begin
                     if (m_ack) begin
                        shreg  <= rd_dat;
                        sda_oe <= ~rd_dat[7];
                        cnt    <= '0;
                        st     <= LK_RDATA;
                     end else begin
                        st <= LK_WAIT;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/lri_regfile.sv
module lri_regfile
   import lri_pkg::*;
#(
   parameter int CHANNELS = 16,
   parameter int IDX_W    = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  upd_stb,
   input  logic [IDX_W-1:0]      upd_idx,
   input  logic [7:0]            upd_dat,
   input  logic [IDX_W-1:0]      rd_idx,
   input  logic [CHANNELS-1:0]   pins,
   output logic [7:0]            rd_dat,
   output logic [7:0]            period_a,
   output logic [7:0]            duty_a,
   output logic [7:0]            period_b,
   output logic [7:0]            duty_b,
   output logic [2*CHANNELS-1:0] ledsel
);

   localparam int N_IN  = CHANNELS / BYTE_W;
   localparam int N_SEL = (2 * CHANNELS) / BYTE_W;
   localparam int N_CFG = N_TIMING + N_SEL;

   logic [N_CFG*BYTE_W-1:0] cfg_flat;

   for (genvar g = 0; g < N_CFG; g++) begin : g_cfg
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= cfg_reset(g);
         else if (upd_stb && upd_idx == IDX_W'(N_IN + g))
            q <= upd_dat;
      end
      assign cfg_flat[g*BYTE_W +: BYTE_W] = q;
   end

   always_comb begin
      rd_dat = '0;
      for (int i = 0; i < N_IN; i++)
         if (rd_idx == IDX_W'(i)) rd_dat = pins[i*BYTE_W +: BYTE_W];
      for (int j = 0; j < N_CFG; j++)
         if (rd_idx == IDX_W'(N_IN + j)) rd_dat = cfg_flat[j*BYTE_W +: BYTE_W];
   end

   assign period_a = cfg_flat[7:0];
   assign duty_a   = cfg_flat[15:8];
   assign period_b = cfg_flat[23:16];
   assign duty_b   = cfg_flat[31:24];
   assign ledsel   = cfg_flat[N_CFG*BYTE_W-1 : N_TIMING*BYTE_W];

endmodule

// File: rtl/led_i2c_regif.sv
module led_i2c_regif
   import lri_pkg::*;
#(
   parameter int CHANNELS = 16,
   parameter int IDX_W    = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [2:0]            dev_sel_i,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_oe_o,
   input  logic [CHANNELS-1:0]   pin_lvl_i,
   output logic [7:0]            period_a_o,
   output logic [7:0]            duty_a_o,
   output logic [7:0]            period_b_o,
   output logic [7:0]            duty_b_o,
   output logic [2*CHANNELS-1:0] ledsel_o,
   output logic                  upd_stb_o,
   output logic [IDX_W-1:0]      upd_idx_o,
   output logic [7:0]            upd_dat_o
);

   localparam int N_IN     = CHANNELS / BYTE_W;
   localparam int LAST_IDX = N_IN + N_TIMING + (2 * CHANNELS) / BYTE_W - 1;

   if (CHANNELS % BYTE_W != 0) begin : g_bad_channels
      $error("CHANNELS must be a multiple of 8");
   end
   if (LAST_IDX >= (1 << IDX_W)) begin : g_bad_idx
      $error("IDX_W too narrow for the register space");
   end
   if (IDX_W > STEP_BIT) begin : g_bad_step
      $error("IDX_W overlaps the auto-step flag");
   end

   logic             scl_rise, scl_fall, start_det, stop_det;
   logic [IDX_W-1:0] ptr_idx;
   logic             ptr_step;
   logic [7:0]       rd_dat;

   lri_bus_edges u_edges (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl       (scl_i),
      .sda       (sda_i),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   lri_link #(
      .IDX_W    (IDX_W),
      .N_IN     (N_IN),
      .LAST_IDX (LAST_IDX)
   ) u_link (
      .clk       (clk),
      .rst_n     (rst_n),
      .dev_sel   (dev_sel_i),
      .sda       (sda_i),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .rd_dat    (rd_dat),
      .ptr_idx   (ptr_idx),
      .ptr_step  (ptr_step),
      .sda_oe    (sda_oe_o),
      .upd_stb   (upd_stb_o),
      .upd_idx   (upd_idx_o),
      .upd_dat   (upd_dat_o)
   );

   lri_regfile #(
      .CHANNELS (CHANNELS),
      .IDX_W    (IDX_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_stb  (upd_stb_o),
      .upd_idx  (upd_idx_o),
      .upd_dat  (upd_dat_o),
      .rd_idx   (ptr_idx),
      .pins     (pin_lvl_i),
      .rd_dat   (rd_dat),
      .period_a (period_a_o),
      .duty_a   (duty_a_o),
      .period_b (period_b_o),
      .duty_b   (duty_b_o),
      .ledsel   (ledsel_o)
   );

endmodule

// File: rtl/lri_checker.sv
module lri_checker #(
   parameter int IDX_W    = 4,
   parameter int N_IN     = 2,
   parameter int LAST_IDX = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl,
   input logic             sda,
   input logic             oe,
   input logic             stb,
   input logic [IDX_W-1:0] widx,
   input logic             step,
   input logic [IDX_W-1:0] pidx
);

   // STOP on the bus always frees the data line (R11)
   assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (scl && $past(scl) && sda && !$past(sda)) |=> !oe);

   // never begins to pull SDA during a high clock phase (R11)
   assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (scl && $past(scl) && !$past(oe)) |-> !oe);

   // strobes only for indices that hold a configuration register (R3)
   assert_strobe_writable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stb |-> (widx >= IDX_W'(N_IN) && widx <= IDX_W'(LAST_IDX)));

   // last index wraps to zero under auto-step (R4)
   assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && step && widx == IDX_W'(LAST_IDX)) |-> pidx == '0);

   // any other index moves up by one under auto-step (R4)
   assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && step && widx != IDX_W'(LAST_IDX)) |-> pidx == widx + 1'b1);

   // pointer holds still without auto-step (R5)
   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && !step) |-> pidx == widx);

   // leaving reset: pointer clear and line released (R10)
   assert_reset_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!oe && pidx == '0 && !step));

endmodule

bind led_i2c_regif lri_checker u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .scl   (scl_i),
   .sda   (sda_i),
   .oe    (sda_oe_o),
   .stb   (upd_stb_o),
   .widx  (upd_idx_o),
   .step  (ptr_step),
   .pidx  (ptr_idx)
);

// File: tb/led_i2c_regif_tb.sv
module led_i2c_regif_tb;

   localparam int         CLK_PERIOD = 10;
   localparam int         HALF       = 6;
   localparam logic [2:0] STRAP      = 3'b101;
   localparam logic [7:0] ADDR_W     = {4'b1100, STRAP, 1'b0};
   localparam logic [7:0] ADDR_R     = {4'b1100, STRAP, 1'b1};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1;
   logic        m_sda = 1'b1;
   logic [15:0] pins = 16'h3C81;
   logic        sda_oe;
   logic [7:0]  period_a, duty_a, period_b, duty_b;
   logic [31:0] ledsel;
   logic        upd_stb;
   logic [3:0]  upd_idx;
   logic [7:0]  upd_dat;
   wire         sda_bus = m_sda & ~sda_oe;

   int n_run = 0;
   int n_fail = 0;
   int n_stb = 0;
   bit done = 0;

   logic [7:0] model [16];
   logic [3:0] mptr;
   logic       mstep;

   logic [7:0] exp_q [$];
   string      tag_q [$];
   logic [7:0] got_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   led_i2c_regif u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .dev_sel_i  (STRAP),
      .scl_i      (scl),
      .sda_i      (sda_bus),
      .sda_oe_o   (sda_oe),
      .pin_lvl_i  (pins),
      .period_a_o (period_a),
      .duty_a_o   (duty_a),
      .period_b_o (period_b),
      .duty_b_o   (duty_b),
      .ledsel_o   (ledsel),
      .upd_stb_o  (upd_stb),
      .upd_idx_o  (upd_idx),
      .upd_dat_o  (upd_dat)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   // monitor: pops expected read bytes as the bus delivers them
   always @(negedge clk) begin
      if (got_q.size() > 0) begin
         logic [7:0] g;
         g = got_q.pop_front();
         if (exp_q.size() == 0) begin
            check(0, "read without expectation", g, 0);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(g == e, t, g, e);
         end
      end
   end

   always @(negedge clk) if (upd_stb) n_stb++;

   initial begin
      repeat (150000) @(posedge clk);
      check(0, "watchdog", 0, 1);
      summary();
   end

   function automatic logic [7:0] model_rd(input logic [3:0] i);
      if (i == 4'd0) return pins[7:0];
      if (i == 4'd1) return pins[15:8];
      if (i <= 4'd9) return model[i];
      return 8'h00;
   endfunction

   function automatic logic [3:0] model_step(input logic [3:0] i);
      return (i == 4'd9) ? 4'd0 : i + 4'd1;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 16; i++) model[i] = 8'h00;
      model[2] = 8'hFF; model[3] = 8'h80; model[4] = 8'hFF; model[5] = 8'h80;
      for (int i = 6; i < 10; i++) model[i] = 8'h55;
      mptr = 4'd0;
      mstep = 1'b0;
   endtask

   task automatic half();
      repeat (HALF) @(negedge clk);
   endtask

   task automatic bit_out(input logic b);
      m_sda = b;
      half();
      scl = 1'b1;
      half();
      scl = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic bit_in(output logic r);
      m_sda = 1'b1;
      half();
      scl = 1'b1;
      half();
      r = sda_bus;
      scl = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; half();
      scl = 1'b1;   half();
      m_sda = 1'b0; half();
      scl = 1'b0;   half();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; half();
      scl = 1'b1;   half();
      m_sda = 1'b1; half();
   endtask

   task automatic wbyte(input logic [7:0] b, output bit ack);
      logic r;
      for (int i = 7; i >= 0; i--) bit_out(b[i]);
      bit_in(r);
      ack = !r;
   endtask

   task automatic rbyte(input bit nack);
      logic [7:0] d;
      logic r;
      for (int i = 7; i >= 0; i--) begin
         bit_in(r);
         d[i] = r;
      end
      bit_out(nack);
      m_sda = 1'b1;
      got_q.push_back(d);
   endtask

   task automatic check_regs(input string tag);
      check(period_a == model[2], {tag, " period A"}, period_a, model[2]);
      check(duty_a == model[3], {tag, " duty A"}, duty_a, model[3]);
      check(period_b == model[4], {tag, " period B"}, period_b, model[4]);
      check(duty_b == model[5], {tag, " duty B"}, duty_b, model[5]);
      check(ledsel == {model[9], model[8], model[7], model[6]}, {tag, " selectors"},
            ledsel, {model[9], model[8], model[7], model[6]});
   endtask

   task automatic send_addr_cmd(input logic [7:0] cmd);
      bit ack;
      wbyte(ADDR_W, ack);
      check(ack, "R1 address ack", ack, 1);
      wbyte(cmd, ack);
      check(ack, "R2 pointer byte ack", ack, 1);
      mptr = cmd[3:0];
      mstep = cmd[4];
   endtask

   task automatic wr_seq(input logic [7:0] cmd, input logic [7:0] d[$], input string tag);
      bit ack;
      bus_start();
      send_addr_cmd(cmd);
      foreach (d[k]) begin
         wbyte(d[k], ack);
         check(ack, {tag, " data ack (R2)"}, ack, 1);
         if (mptr >= 4'd2 && mptr <= 4'd9) model[mptr] = d[k];
         if (mstep) mptr = model_step(mptr);
      end
      bus_stop();
      repeat (4) @(negedge clk);
   endtask

   task automatic rd_bytes(input int n, input string tag);
      for (int k = 0; k < n; k++) begin
         exp_q.push_back(model_rd(mptr));
         tag_q.push_back(tag);
         rbyte(k == n - 1);
         if (mstep) mptr = model_step(mptr);
      end
   endtask

   task automatic ptr_then_read(input logic [7:0] cmd, input int n, input string tag);
      bit ack;
      bus_start();
      send_addr_cmd(cmd);
      bus_start();
      wbyte(ADDR_R, ack);
      check(ack, "R9 read address ack after repeated START", ack, 1);
      rd_bytes(n, tag);
      bus_stop();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      bit ack;
      logic r;
      int stb_before;
      model_reset();
      repeat (5) @(negedge clk);
      // R10: defaults while held in reset
      check_regs("R10 reset");
      check(sda_oe == 1'b0, "R10 SDA released", sda_oe, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1: foreign address is not acknowledged, nor the next byte
      bus_start();
      wbyte({4'b1100, 3'b010, 1'b0}, ack);
      check(!ack, "R1 foreign address ignored", ack, 0);
      wbyte(8'h00, ack);
      check(!ack, "R1 no drive after mismatch", ack, 0);
      bus_stop();
      repeat (4) @(negedge clk);

      // R3 + R4: auto-step across selectors, wrap past 9, drop 0/1, land on 2
      wr_seq(8'h16, '{8'h00, 8'hAA, 8'hFF, 8'h50, 8'h11, 8'h22, 8'h33}, "R4 wrap write");
      check_regs("R4 wrap");
      check(n_stb == 5, "R3 strobe count", n_stb, 5);

      // R3: timing registers
      wr_seq(8'h12, '{8'h2B, 8'h80, 8'h0A, 8'hC0}, "R3 timing");
      check_regs("R3 timing");

      // R5: no auto-step, second byte overwrites same index
      wr_seq(8'h03, '{8'h40, 8'h41}, "R5 fixed");
      check_regs("R5 fixed");
      check(duty_a == 8'h41, "R5 duty A last byte", duty_a, 8'h41);

      // R2: upper pointer bits ignored
      wr_seq(8'hE4, '{8'h77}, "R2 upper bits");
      check(period_b == 8'h77, "R2 upper bits ignored", period_b, 8'h77);

      // R7: input and unused indices drop writes
      stb_before = n_stb;
      wr_seq(8'h00, '{8'h99}, "R7 input write");
      wr_seq(8'h0C, '{8'h99, 8'h98}, "R7 unused write");
      check_regs("R7 dropped writes");
      check(n_stb == stb_before, "R7 no strobe", n_stb, stb_before);

      // R6 + R9: reads through repeated START
      ptr_then_read(8'h13, 4, "R6 config read");
      pins = 16'hA55A;
      ptr_then_read(8'h10, 3, "R6 pin snapshot read");
      // R4: read wraps from 9 to 0
      ptr_then_read(8'h18, 4, "R4 read wrap");
      // R7: unused indices read zero
      ptr_then_read(8'h0C, 2, "R7 unused read");

      // R9: pointer kept across STOP, plain read afterwards
      bus_start();
      send_addr_cmd(8'h07);
      bus_stop();
      repeat (4) @(negedge clk);
      bus_start();
      wbyte(ADDR_R, ack);
      check(ack, "R9 plain read ack", ack, 1);
      rd_bytes(2, "R9 pointer kept");
      bus_stop();
      repeat (4) @(negedge clk);

      // R8: master NACK releases SDA
      ptr_then_read(8'h06, 1, "R8 nacked byte");
      bus_start();
      wbyte(ADDR_R, ack);
      rd_bytes(1, "R8 nacked byte 2");
      for (int k = 0; k < 9; k++) begin
         bit_in(r);
         check(r == 1'b1, "R8 SDA released after NACK", r, 1);
      end
      bus_stop();
      repeat (4) @(negedge clk);

      // R10: reset in the middle of a write
      bus_start();
      send_addr_cmd(8'h16);
      for (int k = 0; k < 4; k++) bit_out(1'b0);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      model_reset();
      check_regs("R10 mid-transfer reset");
      check(sda_oe == 1'b0, "R10 SDA released in reset", sda_oe, 0);
      m_sda = 1'b1;
      scl = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      bus_start();
      wbyte(ADDR_R, ack);
      check(ack, "R10 address ack after reset", ack, 1);
      rd_bytes(1, "R10 pointer cleared");
      bus_stop();

      repeat (20) @(negedge clk);
      check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
      summary();
   end

endmodule